// File: doc/BRIEF.md
# Subtract, Negate and Zero-Extend Unit

This execution unit serves a processor whose instructions are 16 bits long. It takes one register-to-register instruction word, the values already read for the destination register (Rn) and the source register (Rm), and the current T status bit. It decodes the word and produces a 32-bit result for one of seven operations: subtract, subtract with borrow, subtract with signed overflow check, negate, negate with borrow, byte zero-extension and halfword zero-extension. It also reports whether the destination is written, the new T value with an update strobe, and whether the encoding was not recognised.

All inputs are sampled on a rising clock edge. Every output appears from that edge on and is held until the next one, so each instruction takes exactly one cycle. Register file access, fetch and stall control belong to the surrounding pipeline.

Top module: `sne_unit`

## Requirements
- R1: The instruction word splits into group `insn[15:12]`, destination index `insn[11:8]`, source index `insn[7:4]` and function `insn[3:0]`. `dst` and `src` always carry bits 11:8 and 7:4. All outputs reflect the inputs sampled at the previous rising edge.
- R2: Group 4'b0110, function 4'b1100 writes the zero-extended low byte of Rm.
- R3: Group 4'b0110, function 4'b1101 writes the zero-extended low 16 bits of Rm.
- R4: Group 4'b0110, function 4'b1011 writes 0 − Rm, modulo 2^32.
- R5: Group 4'b0110, function 4'b1010 writes 0 − Rm − T. The new T is 1 exactly when Rm + T exceeds 0, taken as an unsigned borrow.
- R6: Group 4'b0011, function 4'b1000 writes Rn − Rm, modulo 2^32.
- R7: Group 4'b0011, function 4'b1010 writes Rn − Rm − T. The new T is 1 exactly when Rm + T is greater than Rn (unsigned).
- R8: Group 4'b0011, function 4'b1011 writes Rn − Rm. The new T is 1 exactly when the true signed difference lies outside −2^31 to 2^31−1.
- R9: Only the R5, R7 and R8 forms raise `t_upd`. For every other word, `t_out` equals the sampled T input.
- R10: Any other encoding raises `illegal`, holds `wr_en` and `t_upd` low and drives `res` to zero. Each of the seven valid forms raises `wr_en` and holds `illegal` low.
- R11: While `rst_n` is low, `res`, `dst`, `src`, `wr_en`, `t_out`, `t_upd` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | 16 | Instruction word |
| rn_val | input | 32 | Value of destination register Rn |
| rm_val | input | 32 | Value of source register Rm |
| t_in | input | 1 | Current T bit |
| res | output | 32 | Result to write to Rn |
| dst | output | 4 | Destination register index |
| src | output | 4 | Source register index, passed on for forwarding compares |
| wr_en | output | 1 | Write enable for Rn |
| t_out | output | 1 | New T value |
| t_upd | output | 1 | T update strobe |
| illegal | output | 1 | Encoding not recognised |

## Verification
The unit holds no state that outlives one instruction. A wrong decode or a wrong borrow or overflow term therefore shows up in the outputs one cycle after the offending word is sampled, and affects only that word. The bench sweeps all 65,536 instruction words, so any decode slip on a valid or invalid encoding is caught as a wrong `wr_en`, `illegal`, `t_upd` or `res`. Corner operands (zero, one, 0x7FFFFFFF, 0x80000000, all ones) with both T values expose off-by-one errors in the borrow and errors in overflow polarity at the boundaries where they flip.

// File: rtl/sne_unit.sv
module sne_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   insn,
  input  logic [DW-1:0] rn_val,
  input  logic [DW-1:0] rm_val,
  input  logic          t_in,
  output logic [DW-1:0] res,
  output logic [3:0]    dst,
  output logic [3:0]    src,
  output logic          wr_en,
  output logic          t_out,
  output logic          t_upd,
  output logic          illegal
);
  localparam int MSB = DW - 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_ZXB, OP_ZXW, OP_NEG, OP_NEGC, OP_SUB, OP_SUBC, OP_SUBV
  } op_e;

  op_e op;
  wire [3:0] grp = insn[15:12];
  wire [3:0] fn  = insn[3:0];

  always_comb begin
    op = OP_NONE;
    if (grp == 4'b0110) begin
      case (fn)
        4'b1100: op = OP_ZXB;
        4'b1101: op = OP_ZXW;
        4'b1011: op = OP_NEG;
        4'b1010: op = OP_NEGC;
        default: op = OP_NONE;
      endcase
    end else if (grp == 4'b0011) begin
      case (fn)
        4'b1000: op = OP_SUB;
        4'b1010: op = OP_SUBC;
        4'b1011: op = OP_SUBV;
        default: op = OP_NONE;
      endcase
    end
  end

  wire is_neg   = (op == OP_NEG) || (op == OP_NEGC);
  wire use_cin  = (op == OP_NEGC) || (op == OP_SUBC);
  wire [DW-1:0] minu = is_neg ? '0 : rn_val;
  wire [DW:0]   diff = {1'b0, minu} - {1'b0, rm_val} - {{DW{1'b0}}, use_cin & t_in};
  wire          ovf  = (rn_val[MSB] ^ rm_val[MSB]) & (diff[MSB] ^ rn_val[MSB]);

  logic [DW-1:0] res_d;
  logic          t_d, tu_d;

  always_comb begin
    res_d = '0;
    t_d   = t_in;
    tu_d  = 1'b0;
    case (op)
      OP_ZXB:  res_d = {{(DW-8){1'b0}}, rm_val[7:0]};
      OP_ZXW:  res_d = {{(DW-16){1'b0}}, rm_val[15:0]};
      OP_NEG, OP_SUB: res_d = diff[DW-1:0];
      OP_NEGC, OP_SUBC: begin
        res_d = diff[DW-1:0];
        t_d   = diff[DW];
        tu_d  = 1'b1;
      end
      OP_SUBV: begin
        res_d = diff[DW-1:0];
        t_d   = ovf;
        tu_d  = 1'b1;
      end
      default: res_d = '0;
    endcase
  end

  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0; dst <= '0; src <= '0;
      wr_en <= 1'b0; t_out <= 1'b0; t_upd <= 1'b0; illegal <= 1'b0;
      live <= 1'b0;
    end else begin
      res     <= res_d;
      dst     <= insn[11:8];
      src     <= insn[7:4];
      wr_en   <= (op != OP_NONE);
      t_out   <= t_d;
      t_upd   <= tu_d;
      illegal <= (op == OP_NONE);
      live    <= 1'b1;
    end
  end

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !t_upd && res == '0));
  p_wr_xor_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (wr_en != illegal));
  p_dst_field_r1: assert property (@(posedge clk) disable iff (!rst_n || !live)
    dst == $past(insn[11:8]));
  p_t_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !t_upd |-> t_out == $past(t_in));
  p_zext_byte_r2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(insn[15:12]) == 4'b0110 && $past(insn[3:0]) == 4'b1100) |-> res[DW-1:8] == '0);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (t_upd && t_out && $past(insn[15:12]) == 4'b0011 && $past(insn[3:0]) == 4'b1011)
      |-> (res[MSB] != $past(rn_val[MSB])));
  p_reset_clear_r11: assert property (@(posedge clk)
    $past(!rst_n) |-> (!wr_en && !t_upd && !illegal));
endmodule

// File: tb/sne_unit_tb.sv
module sne_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] insn = '0;
  logic [31:0] rn_val = '0, rm_val = '0;
  logic t_in = 1'b0;
  logic [31:0] res;
  logic [3:0] dst, src;
  logic wr_en, t_out, t_upd, illegal;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sne_unit dut_i (
    .clk(clk), .rst_n(rst_n), .insn(insn), .rn_val(rn_val), .rm_val(rm_val),
    .t_in(t_in), .res(res), .dst(dst), .src(src), .wr_en(wr_en),
    .t_out(t_out), .t_upd(t_upd), .illegal(illegal)
  );

  function automatic logic [31:0] corner(input int k);
    case (k % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0000_0080;
      6: return 32'h1234_ABCD;
      default: return 32'hFFFF_8000;
    endcase
  endfunction

  function automatic logic [43:0] model(input logic [15:0] i, input logic [31:0] n,
                                        input logic [31:0] m, input logic t, output string tag);
    logic [31:0] r; logic w, to, tu, il;
    longint sd;
    logic [33:0] need;
    r = '0; w = 1'b1; to = t; tu = 1'b0; il = 1'b0;
    need = {2'b0, m} + {33'b0, t};
    if (i[15:12] == 4'h6 && i[3:0] == 4'hC) begin tag = "R2"; r = m & 32'hFF; end
    else if (i[15:12] == 4'h6 && i[3:0] == 4'hD) begin tag = "R3"; r = m & 32'hFFFF; end
    else if (i[15:12] == 4'h6 && i[3:0] == 4'hB) begin tag = "R4"; r = 32'd0 - m; end
    else if (i[15:12] == 4'h6 && i[3:0] == 4'hA) begin
      tag = "R5"; r = 32'd0 - m - {31'b0, t}; tu = 1'b1; to = (need != 0);
    end
    else if (i[15:12] == 4'h3 && i[3:0] == 4'h8) begin tag = "R6"; r = n - m; end
    else if (i[15:12] == 4'h3 && i[3:0] == 4'hA) begin
      tag = "R7"; r = n - m - {31'b0, t}; tu = 1'b1; to = (need > {2'b0, n});
    end
    else if (i[15:12] == 4'h3 && i[3:0] == 4'hB) begin
      tag = "R8"; r = n - m; tu = 1'b1;
      sd = longint'($signed(n)) - longint'($signed(m));
      to = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end
    else begin tag = "R10"; w = 1'b0; il = 1'b1; end
    return {r, i[11:8], i[7:4], w, to, tu, il};
  endfunction

  task automatic apply(input logic [15:0] i, input logic [31:0] n,
                       input logic [31:0] m, input logic t);
    logic [43:0] exp, act;
    string tag;
    insn = i; rn_val = n; rm_val = m; t_in = t;
    exp = model(i, n, m, t, tag);
    @(negedge clk);
    act = {res, dst, src, wr_en, t_out, t_upd, illegal};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s/R1/R9 insn=%h rn=%h rm=%h t=%b act=%h exp=%h", tag, i, n, m, t, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    insn = 16'h3FFA; rn_val = '1; rm_val = '1; t_in = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if ({res, dst, src, wr_en, t_out, t_upd, illegal} !== 44'h0) begin
      bad++;
      $display("FAIL R11 act=%h exp=0", {res, dst, src, wr_en, t_out, t_upd, illegal});
    end
    rst_n = 1'b1;
    // R1 R10: every instruction word, operands cycling through corners
    for (int w = 0; w < 65536; w++)
      apply(16'(w), corner(w), corner(w / 8 + 3), w[4]);
    // R5 R7 R8 R9: valid forms with all corner pairs and both T values
    for (int f = 0; f < 7; f++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int t = 0; t < 2; t++) begin
            logic [15:0] base;
            case (f)
              0: base = 16'h600C; 1: base = 16'h600D; 2: base = 16'h600B;
              3: base = 16'h600A; 4: base = 16'h3008; 5: base = 16'h300A;
              default: base = 16'h300B;
            endcase
            apply(base | 16'((a * 16 + b) << 4), corner(a), corner(b), t[0]);
          end
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] i;
      i = 16'($urandom);
      if (k % 2 == 0) i = {(k % 4 == 0) ? 4'h3 : 4'h6, i[11:4], 4'b1000 | 4'(k % 8)};
      apply(i, $urandom, $urandom, 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule